// File: doc/BRIEF.md
# Byte-Fetch Multicycle 8-bit Datapath

This block is the data side of a small multicycle processor with an 8-bit data path and 32-bit instruction words. An external sequencer drives its control strobes each cycle; the datapath answers with the opcode field, the function field and an ALU zero flag. Every piece of data (program counter, register contents, operand latches, the ALU output latch and the memory data latch) is one byte wide. Only the instruction register is 32 bits wide, and it is filled one byte per cycle through four independent lane enables.

The block talks to a byte-wide memory through an 8-bit address, a read byte and a write byte, so it reaches 256 bytes. Immediates come from the low byte of the instruction and are used unchanged. Byte loads and stores need no offset scaling. The register file has eight entries. The entry at index zero always reads as zero.

Top module: `byte_mc_datapath`

## Requirements
- R1: After a synchronous reset the PC, instruction register, A, B, ALU output latch, memory data latch and all registers are zero, so mem_addr (with ctl_addr_sel=0), opcode, funct and mem_wdata all read 0.
- R2: At a clock edge, ctl_ir_we[k] set loads mem_rdata into instruction bits [8k+7:8k]. Lanes whose enable is clear keep their value. opcode shows instruction bits [31:26] and funct shows bits [5:0].
- R3: The register file holds 8 bytes and is indexed by the low 3 bits of a 5-bit register field. Every clock, A captures the entry selected by instruction bits [25:21] and B captures the entry selected by bits [20:16]. B drives mem_wdata.
- R4: Register index 0 always reads as zero, and writes to it have no effect.
- R5: When ctl_reg_we is set, a register is written at the clock edge. ctl_dst_sel=0 selects destination field [20:16] and 1 selects [15:11]. ctl_wb_sel=0 writes the ALU output latch and 1 writes the memory data latch. The memory data latch captures mem_rdata every clock.
- R6: ctl_alu_op encodes 0 add, 1 subtract, 2 AND, 3 OR and 4 signed set-less-than (result 1 or 0). All other codes give 0. The ALU output latch captures the ALU result every clock.
- R7: ctl_srca_sel=0 feeds the PC to the first ALU operand and 1 feeds A. ctl_srcb_sel encodes the second operand: 0 is B, 1 is the constant 1, 2 is instruction bits [7:0] unchanged, and 3 is the constant 0.
- R8: alu_zero is high in the same cycle that the ALU result is zero.
- R9: ctl_addr_sel=0 drives the PC onto mem_addr and 1 drives the ALU output latch.
- R10: ctl_pc_src encodes the PC's next value: 0 is the ALU result, 1 is the ALU output latch, 2 is instruction bits [5:0] followed by two zero bits, and 3 behaves like 0. The PC loads at the edge when ctl_pc_we is set.
- R11: When ctl_pc_we is clear, the PC loads only if ctl_pc_we_cond is set and alu_zero is high. Otherwise it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory byte address |
| mem_rdata | input | 8 | Byte read from memory |
| mem_wdata | output | 8 | Byte to write to memory (B latch) |
| ctl_addr_sel | input | 1 | Address source: PC or ALU output latch |
| ctl_ir_we | input | 4 | Per-lane instruction register load enables |
| ctl_reg_we | input | 1 | Register file write enable |
| ctl_dst_sel | input | 1 | Destination field select |
| ctl_wb_sel | input | 1 | Write-back source select |
| ctl_srca_sel | input | 1 | First ALU operand select |
| ctl_srcb_sel | input | 2 | Second ALU operand select |
| ctl_alu_op | input | 3 | ALU operation code |
| ctl_pc_src | input | 2 | PC next-value select |
| ctl_pc_we | input | 1 | Unconditional PC load |
| ctl_pc_we_cond | input | 1 | PC load when ALU result is zero |
| opcode | output | 6 | Instruction bits [31:26] |
| funct | output | 6 | Instruction bits [5:0] |
| alu_zero | output | 1 | ALU result is zero |

## Verification
Internal state is not brought out directly. It shows at the ports through routing: the PC and the ALU output latch through the address mux, B through the write byte, and A through an add of zero that is read back one cycle later from the ALU output latch. A wrong instruction byte lane appears at once on opcode or funct, or two cycles later as the wrong register read. A corrupted register appears two cycles after its field is selected. A wrong PC decision appears on mem_addr right after the edge where the PC should have loaded or held.

// File: rtl/bmd_pkg.sv
package bmd_pkg;
    parameter int DW      = 8;
    parameter int IRW     = 32;
    parameter int NREGS   = 8;
    parameter int FIELD_W = 5;
    parameter int OP_W    = 6;

    localparam int LANES  = IRW / DW;
    localparam int RIDX_W = $clog2(NREGS);

    typedef logic [DW-1:0]     word_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        SB_REG  = 2'd0,
        SB_ONE  = 2'd1,
        SB_IMM  = 2'd2,
        SB_ZERO = 2'd3
    } srcb_e;

    typedef enum logic [1:0] {
        PS_ALU    = 2'd0,
        PS_ALUOUT = 2'd1,
        PS_JUMP   = 2'd2,
        PS_ALT    = 2'd3
    } pcsrc_e;

    typedef struct packed {
        logic [OP_W-1:0]    op;
        logic [FIELD_W-1:0] rs;
        logic [FIELD_W-1:0] rt;
        logic [FIELD_W-1:0] rd;
        logic [IRW-OP_W-3*FIELD_W-1:0] low;
    } instr_t;

    function automatic word_t alu_eval(alu_op_e op, word_t x, word_t y);
        word_t r;
        case (op)
            ALU_ADD: r = x + y;
            ALU_SUB: r = x - y;
            ALU_AND: r = x & y;
            ALU_OR:  r = x | y;
            ALU_SLT: r = ($signed(x) < $signed(y)) ? word_t'(1) : word_t'(0);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic word_t jump_target(logic [OP_W-1:0] f);
        return word_t'({f, 2'b00});
    endfunction

    function automatic ridx_t field_to_idx(logic [FIELD_W-1:0] f);
        return f[RIDX_W-1:0];
    endfunction
endpackage

// File: rtl/bmd_instr_reg.sv
module bmd_instr_reg
    import bmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] lane_we,
    input  word_t            byte_in,
    output instr_t           instr
);
    logic [IRW-1:0] ir_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                ir_q[g*DW +: DW] <= '0;
            else if (lane_we[g])
                ir_q[g*DW +: DW] <= byte_in;
        end
    end

    assign instr = instr_t'(ir_q);

    assert_ir_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (lane_we == '0) |=> $stable(ir_q));
endmodule

// File: rtl/bmd_regfile.sv
module bmd_regfile
    import bmd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ridx_t rd_idx_a,
    input  ridx_t rd_idx_b,
    output word_t rd_a,
    output word_t rd_b,
    input  logic  wr_en,
    input  ridx_t wr_idx,
    input  word_t wr_data
);
    word_t entry [NREGS];

    assign entry[0] = '0;

    for (genvar g = 1; g < NREGS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entry[g] <= '0;
            else if (wr_en && wr_idx == ridx_t'(g))
                entry[g] <= wr_data;
        end
    end

    assign rd_a = entry[rd_idx_a];
    assign rd_b = entry[rd_idx_b];
endmodule

// File: rtl/bmd_alu.sv
module bmd_alu
    import bmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  alu_op_e op,
    input  word_t   x,
    input  word_t   y,
    output word_t   result,
    output logic    zero
);
    assign result = alu_eval(op, x, y);
    assign zero   = (result == '0);

    assert_slt_bool_R6: assert property (@(posedge clk) disable iff (rst)
        (op == ALU_SLT) |-> (result[DW-1:1] == '0));
endmodule

// File: rtl/byte_mc_datapath.sv
module byte_mc_datapath
    import bmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [DW-1:0]    mem_addr,
    input  logic [DW-1:0]    mem_rdata,
    output logic [DW-1:0]    mem_wdata,
    input  logic             ctl_addr_sel,
    input  logic [LANES-1:0] ctl_ir_we,
    input  logic             ctl_reg_we,
    input  logic             ctl_dst_sel,
    input  logic             ctl_wb_sel,
    input  logic             ctl_srca_sel,
    input  logic [1:0]       ctl_srcb_sel,
    input  logic [2:0]       ctl_alu_op,
    input  logic [1:0]       ctl_pc_src,
    input  logic             ctl_pc_we,
    input  logic             ctl_pc_we_cond,
    output logic [OP_W-1:0]  opcode,
    output logic [5:0]       funct,
    output logic             alu_zero
);
    instr_t ir;
    word_t  pc_q, a_q, b_q, aluout_q, mdr_q;
    word_t  rf_a, rf_b, src_a, src_b, alu_y, pc_next, wb_data;
    ridx_t  rs_idx, rt_idx, dst_idx;
    logic   pc_load;

    bmd_instr_reg u_ir (
        .clk     (clk),
        .rst     (rst),
        .lane_we (ctl_ir_we),
        .byte_in (mem_rdata),
        .instr   (ir)
    );

    assign rs_idx  = field_to_idx(ir.rs);
    assign rt_idx  = field_to_idx(ir.rt);
    assign dst_idx = ctl_dst_sel ? field_to_idx(ir.rd) : rt_idx;
    assign wb_data = ctl_wb_sel ? mdr_q : aluout_q;

    bmd_regfile u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd_idx_a (rs_idx),
        .rd_idx_b (rt_idx),
        .rd_a     (rf_a),
        .rd_b     (rf_b),
        .wr_en    (ctl_reg_we),
        .wr_idx   (dst_idx),
        .wr_data  (wb_data)
    );

    always_comb begin
        src_a = ctl_srca_sel ? a_q : pc_q;
        case (srcb_e'(ctl_srcb_sel))
            SB_REG:  src_b = b_q;
            SB_ONE:  src_b = word_t'(1);
            SB_IMM:  src_b = ir.low[DW-1:0];
            default: src_b = '0;
        endcase
    end

    bmd_alu u_alu (
        .clk    (clk),
        .rst    (rst),
        .op     (alu_op_e'(ctl_alu_op)),
        .x      (src_a),
        .y      (src_b),
        .result (alu_y),
        .zero   (alu_zero)
    );

    always_comb begin
        case (pcsrc_e'(ctl_pc_src))
            PS_ALUOUT: pc_next = aluout_q;
            PS_JUMP:   pc_next = jump_target(ir.low[5:0]);
            default:   pc_next = alu_y;
        endcase
    end

    assign pc_load = ctl_pc_we | (ctl_pc_we_cond & alu_zero);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            a_q      <= '0;
            b_q      <= '0;
            aluout_q <= '0;
            mdr_q    <= '0;
        end else begin
            if (pc_load)
                pc_q <= pc_next;
            a_q      <= rf_a;
            b_q      <= rf_b;
            aluout_q <= alu_y;
            mdr_q    <= mem_rdata;
        end
    end

    assign mem_addr  = ctl_addr_sel ? aluout_q : pc_q;
    assign mem_wdata = b_q;
    assign opcode    = ir.op;
    assign funct     = ir.low[5:0];

    assert_r0_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rs_idx == '0) |=> (a_q == '0));

    assert_pc_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!ctl_pc_we && !(ctl_pc_we_cond && alu_zero)) |=> $stable(pc_q));

    assert_jump_aligned_R10: assert property (@(posedge clk) disable iff (rst)
        (ctl_pc_we && ctl_pc_src == PS_JUMP) |=> (pc_q[1:0] == 2'b00));

    assert_zero_latched_R8: assert property (@(posedge clk) disable iff (rst)
        alu_zero |=> (aluout_q == '0));
endmodule

// File: tb/byte_mc_datapath_bench.sv
module byte_mc_datapath_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] mem_addr, mem_rdata, mem_wdata;
    logic       ctl_addr_sel, ctl_reg_we, ctl_dst_sel, ctl_wb_sel, ctl_srca_sel;
    logic [3:0] ctl_ir_we;
    logic [1:0] ctl_srcb_sel, ctl_pc_src;
    logic [2:0] ctl_alu_op;
    logic       ctl_pc_we, ctl_pc_we_cond;
    logic [5:0] opcode, funct;
    logic       alu_zero;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    byte_mc_datapath u_byte_mc_datapath (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .ctl_addr_sel(ctl_addr_sel), .ctl_ir_we(ctl_ir_we),
        .ctl_reg_we(ctl_reg_we), .ctl_dst_sel(ctl_dst_sel), .ctl_wb_sel(ctl_wb_sel),
        .ctl_srca_sel(ctl_srca_sel), .ctl_srcb_sel(ctl_srcb_sel), .ctl_alu_op(ctl_alu_op),
        .ctl_pc_src(ctl_pc_src), .ctl_pc_we(ctl_pc_we), .ctl_pc_we_cond(ctl_pc_we_cond),
        .opcode(opcode), .funct(funct), .alu_zero(alu_zero)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        ctl_addr_sel = 0; ctl_ir_we = 0; ctl_reg_we = 0; ctl_dst_sel = 0;
        ctl_wb_sel = 0; ctl_srca_sel = 0; ctl_srcb_sel = 0; ctl_alu_op = 0;
        ctl_pc_src = 0; ctl_pc_we = 0; ctl_pc_we_cond = 0; mem_rdata = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [4:0] rd,
                                       input logic [7:0] imm);
        return {op, rs, rt, rd, 3'b000, imm};
    endfunction

    task automatic load_ir(input logic [31:0] w);
        for (int k = 0; k < 4; k++) begin
            ctl_ir_we = 4'(1 << k);
            mem_rdata = w[k*8 +: 8];
            tick();
        end
        ctl_ir_we = 0;
        mem_rdata = 0;
    endtask

    task automatic write_reg(input logic [4:0] idx, input logic [7:0] val);
        load_ir(mk(0, 0, idx, 0, 0));
        mem_rdata = val;
        tick();
        mem_rdata = 0;
        ctl_reg_we = 1; ctl_wb_sel = 1; ctl_dst_sel = 0;
        tick();
        ctl_reg_we = 0; ctl_wb_sel = 0;
    endtask

    task automatic read_regs(input logic [4:0] rs, input logic [4:0] rt,
                             output logic [7:0] a, output logic [7:0] b);
        load_ir(mk(0, rs, rt, 0, 0));
        ctl_srca_sel = 1; ctl_srcb_sel = 2'd3; ctl_alu_op = 3'd0;
        tick();
        tick();
        b = mem_wdata;
        ctl_addr_sel = 1;
        #1;
        a = mem_addr;
        idle();
    endtask

    task automatic t_reset();
        #1;
        check("R1 pc on mem_addr", mem_addr, 8'h00);
        check("R1 opcode", opcode, 6'h00);
        check("R1 funct", funct, 6'h00);
        check("R1 B on mem_wdata", mem_wdata, 8'h00);
        check("R8 zero with 0+0", alu_zero, 1'b1);
    endtask

    task automatic t_ir_lanes();
        load_ir(32'hA4C3_1E57);
        check("R2 opcode full word", opcode, 6'h29);
        check("R2 funct full word", funct, 6'h17);
        ctl_ir_we = 4'b1000; mem_rdata = 8'hFC; tick(); idle();
        check("R2 lane3 only opcode", opcode, 6'h3F);
        check("R2 lane3 only funct kept", funct, 6'h17);
        ctl_ir_we = 4'b0001; mem_rdata = 8'h00; tick(); idle();
        check("R2 lane0 only funct", funct, 6'h00);
        check("R2 lane0 only opcode kept", opcode, 6'h3F);
    endtask

    task automatic t_regs();
        logic [7:0] a, b;
        write_reg(5'd3, 8'h5A);
        write_reg(5'd5, 8'hC3);
        read_regs(5'd3, 5'd5, a, b);
        check("R3 A from rs field", a, 8'h5A);
        check("R3 B on mem_wdata", b, 8'hC3);
        write_reg(5'd0, 8'h77);
        read_regs(5'd0, 5'd0, a, b);
        check("R4 r0 via A", a, 8'h00);
        check("R4 r0 via B", b, 8'h00);
        write_reg(5'd13, 8'h3C);
        read_regs(5'd5, 5'd13, a, b);
        check("R3 index low bits via A", a, 8'h3C);
        check("R3 index low bits via B", b, 8'h3C);
    endtask

    task automatic t_dst_wb();
        logic [7:0] a, b;
        load_ir(mk(0, 0, 5'd2, 5'd6, 0));
        mem_rdata = 8'h81; tick();
        mem_rdata = 0; ctl_reg_we = 1; ctl_wb_sel = 1; ctl_dst_sel = 1; tick(); idle();
        read_regs(5'd6, 5'd2, a, b);
        check("R5 rd field written", a, 8'h81);
        check("R5 rt field untouched", b, 8'h00);
        load_ir(mk(0, 0, 0, 5'd4, 8'h9C));
        ctl_srca_sel = 1; ctl_srcb_sel = 2'd2; ctl_alu_op = 3'd0;
        tick(); tick();
        ctl_reg_we = 1; ctl_dst_sel = 1; ctl_wb_sel = 0; tick(); idle();
        read_regs(5'd4, 5'd0, a, b);
        check("R5 R7 ALU latch write-back of imm", a, 8'h9C);
    endtask

    task automatic t_alu(input logic [2:0] op, input logic [7:0] x, input logic [7:0] y,
                         input logic [7:0] exp, input string tag);
        write_reg(5'd1, x);
        write_reg(5'd2, y);
        load_ir(mk(0, 5'd1, 5'd2, 0, 0));
        ctl_srca_sel = 1; ctl_srcb_sel = 0; ctl_alu_op = op;
        tick();
        check({"R8 zero ", tag}, alu_zero, exp == 8'h00);
        tick();
        ctl_addr_sel = 1;
        #1;
        check({"R6 result ", tag}, mem_addr, exp);
        idle();
    endtask

    task automatic t_pc();
        ctl_srca_sel = 0; ctl_srcb_sel = 2'd1; ctl_alu_op = 0; ctl_pc_src = 0; ctl_pc_we = 1;
        tick(); tick(); idle(); #1;
        check("R10 R9 pc+1 twice", mem_addr, 8'h02);
        load_ir(mk(0, 0, 0, 0, 8'h2B));
        ctl_pc_src = 2'd2; ctl_pc_we = 1; tick(); idle(); #1;
        check("R10 jump target", mem_addr, 8'hAC);
    endtask

    task automatic t_branch(input logic [7:0] y, input logic [7:0] exp_pc, input string tag);
        write_reg(5'd1, 8'h44);
        write_reg(5'd2, y);
        load_ir(mk(0, 5'd1, 5'd2, 0, 8'h10));
        tick();
        ctl_srca_sel = 0; ctl_srcb_sel = 2'd2; ctl_alu_op = 0;
        tick();
        ctl_srca_sel = 1; ctl_srcb_sel = 0; ctl_alu_op = 3'd1;
        ctl_pc_src = 2'd1; ctl_pc_we_cond = 1;
        tick(); idle(); #1;
        check({"R11 ", tag}, mem_addr, exp_pc);
    endtask

    initial begin
        #(8 * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        tick(); tick();
        rst = 0;
        t_reset();
        t_ir_lanes();
        t_regs();
        t_dst_wb();
        t_alu(3'd0, 8'h70, 8'hA0, 8'h10, "add");
        t_alu(3'd1, 8'h05, 8'h05, 8'h00, "sub");
        t_alu(3'd2, 8'hF0, 8'h3C, 8'h30, "and");
        t_alu(3'd3, 8'hF0, 8'h3C, 8'hFC, "or");
        t_alu(3'd4, 8'hFF, 8'h01, 8'h01, "slt neg<pos");
        t_alu(3'd4, 8'h01, 8'hFF, 8'h00, "slt pos<neg");
        t_alu(3'd4, 8'h80, 8'h7F, 8'h01, "slt min<max");
        t_alu(3'd7, 8'h12, 8'h34, 8'h00, "unused code");
        t_pc();
        t_branch(8'h44, 8'hBC, "taken branch");
        t_branch(8'h45, 8'hBC, "not taken branch");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule